// File: doc/BRIEF.md
# Serial Control Register Write Port

This block is the configuration entry point of a data converter. A host drives three wires: a serial clock, a serial data line and an active-low select. The port samples the data line on each falling edge of the serial clock while select is low. It packs the bits into 16-bit words, most significant bit first. The upper four bits of each word name a target register and the lower twelve carry the payload. Each completed word updates at most one of three control fields: a flag that disables the clock-alignment loop, a two-bit output test-pattern selector, and a power-down flag. All three are driven straight out as plain control pins.

The three serial wires are asynchronous to the system clock. Each one passes through its own two-stage synchronizer, and serial clock edges are detected in the system clock domain, so the system clock must run at least four times faster than the serial clock. The serial input is a push-only stream. The host paces it, there is no ready signal and no back-pressure, and a word is accepted at the exact moment its sixteenth bit is sampled. A host may stream any number of words inside one select window. Bits left over at the end of a window that do not fill a word are thrown away. The port cannot be read back.

Top module: `cfg_serial_port`

## Requirements
- R1: A synchronous reset drives all three control outputs (`clkloop_off`, `test_sel`, `pwr_down`) to zero.
- R2: A word is taken MSB first, with bits 15:12 as the address and bits 11:0 as the payload. A word at address 4'b1101 loads payload bit 1 into `clkloop_off`.
- R3: A word at address 4'b1110 loads payload bits 10:9 into `test_sel` (bit 10 to `test_sel[1]`).
- R4: A word at address 4'b1111 loads payload bit 11 into `pwr_down`.
- R5: A word at any address other than 1101, 1110 or 1111 changes no output. A word at a decoded address leaves the outputs owned by the other two addresses unchanged.
- R6: Several consecutive words sent inside one select-low window are each committed at their own sixteenth falling edge, in order.
- R7: Trailing bits that do not complete a word when select rises are discarded. A window that holds fewer than 16 bits writes nothing.
- R8: Serial clock falling edges while select is high are ignored. Every select-low window starts word alignment from bit count zero.
- R9: After the sixteenth falling edge of a word appears at the port, the updated output is visible after at most four rising edges of the system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial clock from host, asynchronous |
| ser_dat | input | 1 | Serial data from host, asynchronous |
| ser_sel_n | input | 1 | Active-low select that frames a transfer window |
| clkloop_off | output | 1 | Disables the clock-alignment loop when 1 |
| test_sel | output | 2 | Output test-pattern selector, 0 is normal operation |
| pwr_down | output | 1 | Power-down request when 1 |

## Verification
The bench sweeps every address with four payloads (all ones, all zeros, and the two alternating patterns) against an arithmetic model. A decoder that took the wrong bit, let an undecoded address disturb a field, or wrote the wrong field would show a mismatch on the bus of all three outputs. Back-to-back words in one window catch a counter that does not wrap cleanly after sixteen bits. A short window and a 20-bit window catch a design that commits partial words or carries stray bits into the next window. Serial clock edges with select high, followed by an aligned word, show whether the bit counter really clears between windows.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  localparam int WORD_W = 16;
  localparam int ADDR_W = 4;
  localparam int DATA_W = WORD_W - ADDR_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  localparam addr_t ADR_CLKLOOP = 4'b1101;
  localparam addr_t ADR_PATTERN = 4'b1110;
  localparam addr_t ADR_POWER   = 4'b1111;

  localparam int CLKLOOP_BIT = 1;
  localparam int PATTERN_LSB = 9;
  localparam int PATTERN_W   = 2;
  localparam int POWER_BIT   = 11;

  typedef struct packed {
    logic                 pwr;
    logic [PATTERN_W-1:0] pat;
    logic                 loop_off;
  } ctrl_t;

endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
  parameter int         W       = 3,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);

  logic [STAGES-1:0][W-1:0] stg;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) stg <= {STAGES{RST_VAL}};
        else     stg <= d_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) stg <= {STAGES{RST_VAL}};
        else     stg <= {stg[STAGES-2:0], d_in};
      end
    end
  endgenerate

  assign d_out = stg[STAGES-1];

endmodule

// File: rtl/cfgp_framer.sv
module cfgp_framer #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              sel_n_s,
  output logic              word_vld,
  output logic [WORD_W-1:0] word
);

  localparam int              CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(WORD_W - 1);

  logic              sclk_d;
  logic              fall;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-2:0] shreg;

  // falling edge seen in the system domain, only inside a window
  assign fall = sclk_d & ~sclk_s & ~sel_n_s;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      shreg    <= '0;
      word     <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (sel_n_s) begin
        cnt <= '0;
      end else if (fall) begin
        if (cnt == LAST) begin
          word     <= {shreg, sdat_s};
          word_vld <= 1'b1;
          cnt      <= '0;
        end else begin
          shreg <= {shreg[WORD_W-3:0], sdat_s};
          cnt   <= cnt + 1'b1;
        end
      end
    end
  end

  // R8: a deselected cycle always leaves the counter at zero
  p_cnt_restart_r8: assert property (@(posedge clk) disable iff (rst)
    sel_n_s |=> (cnt == '0));

  // R7: nothing is committed on the cycle after a deselected one
  p_no_word_idle_r7: assert property (@(posedge clk) disable iff (rst)
    sel_n_s |=> !word_vld);

  // R6: each commit is a single-cycle pulse
  p_vld_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> !word_vld);

endmodule

// File: rtl/cfgp_regbank.sv
module cfgp_regbank
  import cfgp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_vld,
  input  logic [WORD_W-1:0] wr_word,
  output ctrl_t             ctrl
);

  addr_t wr_addr;
  data_t wr_data;

  assign wr_addr = wr_word[WORD_W-1 -: ADDR_W];
  assign wr_data = wr_word[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr_vld) begin
      unique case (wr_addr)
        ADR_CLKLOOP: ctrl.loop_off <= wr_data[CLKLOOP_BIT];
        ADR_PATTERN: ctrl.pat      <= wr_data[PATTERN_LSB +: PATTERN_W];
        ADR_POWER:   ctrl.pwr      <= wr_data[POWER_BIT];
        default:     ;
      endcase
    end
  end

  // R1
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (ctrl == '0));

  // R5: no write, no change
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !wr_vld |=> $stable(ctrl));

  // R5: undecoded addresses leave all fields alone
  p_ignore_other_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_vld && wr_addr != ADR_CLKLOOP && wr_addr != ADR_PATTERN && wr_addr != ADR_POWER)
      |=> $stable(ctrl));

  // R2
  p_loop_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_vld && wr_addr == ADR_CLKLOOP)
      |=> (ctrl.loop_off == $past(wr_data[CLKLOOP_BIT])) && $stable(ctrl.pat) && $stable(ctrl.pwr));

  // R3
  p_pat_write_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_vld && wr_addr == ADR_PATTERN)
      |=> (ctrl.pat == $past(wr_data[PATTERN_LSB +: PATTERN_W])) && $stable(ctrl.loop_off) && $stable(ctrl.pwr));

  // R4
  p_pwr_write_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_vld && wr_addr == ADR_POWER)
      |=> (ctrl.pwr == $past(wr_data[POWER_BIT])) && $stable(ctrl.loop_off) && $stable(ctrl.pat));

  // R2: a committed word carries no unknown bits
  p_payload_known_r2: assert property (@(posedge clk) disable iff (rst)
    wr_vld |-> !$isunknown(wr_word));

endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfgp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ser_clk,
  input  logic       ser_dat,
  input  logic       ser_sel_n,
  output logic       clkloop_off,
  output logic [1:0] test_sel,
  output logic       pwr_down
);

  logic [2:0]        raw;
  logic [2:0]        syn;
  logic              word_vld;
  logic [WORD_W-1:0] word;
  ctrl_t             ctrl;

  // order: {select_n, data, clock}; select idles high after reset
  assign raw = {ser_sel_n, ser_dat, ser_clk};

  cfgp_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (raw),
    .d_out (syn)
  );

  cfgp_framer #(
    .WORD_W (WORD_W)
  ) u_framer (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (syn[0]),
    .sdat_s   (syn[1]),
    .sel_n_s  (syn[2]),
    .word_vld (word_vld),
    .word     (word)
  );

  cfgp_regbank u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_vld  (word_vld),
    .wr_word (word),
    .ctrl    (ctrl)
  );

  assign clkloop_off = ctrl.loop_off;
  assign test_sel    = ctrl.pat;
  assign pwr_down    = ctrl.pwr;

endmodule

// File: tb/test_cfg_serial_port.sv
`timescale 1ns/1ps
module test_cfg_serial_port;

  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_clk = 1'b1;
  logic       ser_dat = 1'b0;
  logic       ser_sel_n = 1'b1;
  logic       clkloop_off;
  logic [1:0] test_sel;
  logic       pwr_down;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  logic       m_loop = 1'b0;
  logic [1:0] m_pat  = 2'b00;
  logic       m_pwr  = 1'b0;

  always #5 clk = ~clk;

  cfg_serial_port i_cfg_serial_port (
    .clk         (clk),
    .rst         (rst),
    .ser_clk     (ser_clk),
    .ser_dat     (ser_dat),
    .ser_sel_n   (ser_sel_n),
    .clkloop_off (clkloop_off),
    .test_sel    (test_sel),
    .pwr_down    (pwr_down)
  );

  function automatic logic [3:0] model_now();
    return {m_pwr, m_pat, m_loop};
  endfunction

  task automatic model_write(input logic [15:0] w);
    case (w[15:12])
      4'b1101: m_loop = w[1];
      4'b1110: m_pat  = w[10:9];
      4'b1111: m_pwr  = w[11];
      default: ;
    endcase
  endtask

  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] got;
    got = {pwr_down, test_sel, clkloop_off};
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs {pwr,sel,loop} got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    @(negedge clk);
    ser_clk = 1'b1;
    ser_dat = b;
    repeat (HALF) @(negedge clk);
    ser_clk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
  endtask

  task automatic open_win();
    @(negedge clk);
    ser_sel_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic close_win();
    @(negedge clk);
    ser_clk = 1'b1;
    repeat (2) @(negedge clk);
    ser_sel_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  // sends one word, checks the result exactly four rising edges after the last fall
  task automatic word_timed(input logic [15:0] w, input string tag);
    shift_bits({16'h0, w} >> 1, 15);
    @(negedge clk);
    ser_clk = 1'b1;
    ser_dat = w[0];
    repeat (HALF) @(negedge clk);
    ser_clk = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    model_write(w);
    chk(tag, model_now());
    repeat (HALF) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] pay;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 reset state", 4'b0000);

    // sweep: every address, four payloads
    for (int a = 0; a < 16; a++) begin
      for (int p = 0; p < 4; p++) begin
        pay = (p == 0) ? 12'hFFF : (p == 1) ? 12'h000 : (p == 2) ? 12'hAAA : 12'h555;
        open_win();
        case (a)
          13:      word_timed({a[3:0], pay}, "R2 R9 clock-loop sweep");
          14:      word_timed({a[3:0], pay}, "R3 R9 pattern sweep");
          15:      word_timed({a[3:0], pay}, "R4 R9 power sweep");
          default: word_timed({a[3:0], pay}, "R5 undecoded sweep");
        endcase
        close_win();
      end
    end

    // R5: undecoded address after fields are set
    open_win();
    word_timed(16'hD002, "R2 set loop");
    word_timed(16'hE600, "R3 set pattern 3");
    word_timed(16'hF800, "R4 set power");
    word_timed(16'h0FFF, "R5 undecoded with all set");
    word_timed(16'hCFFF, "R5 address 1100 ignored");
    close_win();
    chk("R5 fields kept", 4'b1111);

    // R6: several words in one window, order matters
    open_win();
    word_timed(16'hD000, "R6 first word");
    word_timed(16'hE200, "R6 second word");
    word_timed(16'hF000, "R6 third word");
    word_timed(16'hE400, "R6 fourth word");
    close_win();
    chk("R6 after window", model_now());

    // R7: short window writes nothing
    open_win();
    shift_bits(32'h0000_F800 >> 9, 7);
    close_win();
    chk("R7 seven-bit window", model_now());

    // R7: 20-bit window, trailing four bits dropped
    open_win();
    shift_bits(32'h000F_800F, 20);
    model_write(16'hF800);
    close_win();
    chk("R7 word then tail", model_now());
    open_win();
    word_timed(16'hD002, "R7 alignment after tail");
    close_win();

    // R8: falls while deselected are ignored
    ser_dat = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); ser_clk = 1'b0;
      repeat (HALF) @(negedge clk); ser_clk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    chk("R8 no change while deselected", model_now());
    open_win();
    word_timed(16'hE000, "R8 aligned after stray edges");
    close_win();

    // R1: reset clears a nonzero state
    chk("R1 pre-reset state", 4'b1001);
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    m_loop = 1'b0; m_pat = 2'b00; m_pwr = 1'b0;
    @(negedge clk);
    chk("R1 reset clears fields", 4'b0000);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule